// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Glitch-Free Gating

This block takes a fast source clock and produces a divided clock at 1, 1/2, 1/4 or 1/8 of its rate, selected by a small binary code. An active-high enable gates the result. Alongside the divided clock it drives a complement copy, so a later stage can build a differential pair from it. Typical use: the last stage of a frequency synthesizer. There the source runs somewhere between 200 and 400 MHz and the output lands between 25 and 400 MHz.

The divide code and the enable may change at any time, including in the middle of an output period. Neither one is obeyed at once. Both are sampled only on the clock edge where the output period counter wraps to zero. A new setting therefore always begins with a complete output period, and no shortened high or low pulse can appear. Divide-by-1 cannot come out of a register, so it is produced by gating the source clock. That gate is captured on the falling edge, while the source clock is low. The bypass path and the counter path are therefore swapped only while the output is low.

Top module: `pow2_clk_div`

## Requirements
- R1: Divide code 0 (binary 00) gives an output period of 1 source cycle, code 1 (01) gives 2, code 2 (10) gives 4 and code 3 (11) gives 8.
- R2: For ratios of 2 or more, the output is high for the first half of each period and low for the second half. At ratio 1 it follows the source clock's high phase.
- R3: While the adopted enable is low, the output stays low and the complement output stays high.
- R4: The enable input is sampled only on a wrap edge (the counter is at its last count for the current ratio). Changes at any other time have no effect on the output.
- R5: The divide code is sampled only on a wrap edge. Changes between wrap edges leave the current period and ratio untouched.
- R6: Switching between ratio 1 and any other ratio, in either direction, produces no high or low pulse shorter than half a source cycle, and the output is never driven from both paths at once.
- R7: The complement output is always the inverse of the divided output.
- R8: An asynchronous reset clears the period counter, selects ratio 1 with the enable off, and holds the output low (complement high).
- R9: A setting sampled on a wrap edge shapes the output from the next source cycle onward. The first output cycle after the switch is the high start of a full new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Fast source clock |
| rst | input | 1 | Asynchronous reset, active high |
| div_code | input | 2 | Ratio select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| out_en | input | 1 | Output enable, active high, sampled at period boundaries |
| clk_out | output | 1 | Divided, gated clock |
| clk_out_n | output | 1 | Complement of clk_out |

## Verification
The bench builds the block with its default 2-bit code. That brings all four ratios within reach, including the bypass-to-counter crossover at both ends of the range (1 and 8). A behavioural model tracks ratio, phase and enable in plain integers. The bench checks the output in both the high and the low half of every source cycle, which exposes any short pulse at a switch. Directed phases change the code and the enable in the middle of long periods, alternate rapidly between /1 and the counter ratios, and apply a second reset while the output is running. Each ratio is also measured by counting output rising edges over a fixed window.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

  // Output period in source cycles for a given shift amount.
  function automatic int unsigned ratio_of(input int unsigned shift);
    return 32'd1 << shift;
  endfunction

  // Number of leading source cycles during which the output is high.
  function automatic int unsigned high_len_of(input int unsigned shift);
    return ratio_of(shift) >> 1;
  endfunction

  // Last counter value before the period wraps.
  function automatic int unsigned last_count_of(input int unsigned shift);
    return ratio_of(shift) - 32'd1;
  endfunction

endpackage

// File: rtl/odiv_sequencer.sv
module odiv_sequencer
  import odiv_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int CNT_W = (2 ** CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              en_in,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CODE_W-1:0] sel_q,
  output logic              en_q,
  output logic              wrap
);

  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(last_count_of(int'(sel_q)));
  assign wrap     = (cnt_q == last_cnt);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sel_q <= code_in;
      en_q  <= en_in;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(sel_q));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(en_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(last_count_of(int'(sel_q))));

  // R8
  cnt_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (cnt_q == '0));

endmodule

// File: rtl/odiv_shaper.sv
module odiv_shaper
  import odiv_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int CNT_W = (2 ** CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CODE_W-1:0] sel_q,
  input  logic              en_q,
  output logic              div_q,
  output logic              byp_gate
);

  logic             use_bypass;
  logic [CNT_W-1:0] high_len;
  logic             div_next;

  assign use_bypass = (sel_q == '0);
  assign high_len   = CNT_W'(high_len_of(int'(sel_q)));
  assign div_next   = en_q && !use_bypass && (cnt_q < high_len);

  // Counter path: registered level for ratios of two and above.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) div_q <= 1'b0;
    else     div_q <= div_next;
  end

  // Bypass path gate: captured while the source clock is low.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) byp_gate <= 1'b0;
    else     byp_gate <= en_q && use_bypass;
  end

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> ($past(cnt_q) == '0));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(div_q && byp_gate));

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !div_q);

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import odiv_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int CNT_W = (2 ** CODE_W) - 1
) (
  input  logic              src_clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  input  logic              out_en,
  output logic              clk_out,
  output logic              clk_out_n
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sel_q;
  logic              en_q;
  logic              wrap;
  logic              div_q;
  logic              byp_gate;
  logic              byp_term;

  odiv_sequencer #(.CODE_W(CODE_W)) u_seq (
    .clk     (src_clk),
    .rst     (rst),
    .code_in (div_code),
    .en_in   (out_en),
    .cnt_q   (cnt_q),
    .sel_q   (sel_q),
    .en_q    (en_q),
    .wrap    (wrap)
  );

  odiv_shaper #(.CODE_W(CODE_W)) u_shp (
    .clk      (src_clk),
    .rst      (rst),
    .cnt_q    (cnt_q),
    .sel_q    (sel_q),
    .en_q     (en_q),
    .div_q    (div_q),
    .byp_gate (byp_gate)
  );

  assign byp_term  = src_clk & byp_gate;
  assign clk_out   = byp_term | div_q;
  assign clk_out_n = ~clk_out;

  // R8
  reset_low_chk: assert property (@(posedge src_clk)
    rst |-> (!div_q && !byp_gate));

  // R4
  en_adopt_chk: assert property (@(posedge src_clk) disable iff (rst)
    wrap |=> (en_q == $past(out_en)));

endmodule

// File: tb/tb_pow2_clk_div.sv
module tb_pow2_clk_div;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] code;
  logic       oe;
  wire        clk_out;
  wire        clk_out_n;

  always #2 clk = ~clk;

  pow2_clk_div dut (
    .src_clk   (clk),
    .rst       (rst),
    .div_code  (code),
    .out_en    (oe),
    .clk_out   (clk_out),
    .clk_out_n (clk_out_n)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R8";
  bit    done     = 1'b0;

  // Behavioural reference: period length, position in period, enable.
  int m_ratio;
  int m_ph;
  bit m_en;
  bit exp_hi;
  bit exp_lo;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_ratio = 1; m_ph = 0; m_en = 0; exp_hi = 0; exp_lo = 0;
    end else begin
      exp_hi = m_en && ((m_ratio == 1) || (m_ph < m_ratio / 2));
      exp_lo = m_en && (m_ratio > 1) && (m_ph < m_ratio / 2);
      if (m_ph == m_ratio - 1) begin
        m_ratio = 1 << code;
        m_en    = oe;
        m_ph    = 0;
      end else begin
        m_ph = m_ph + 1;
      end
    end
  end

  // Rise counter for the ratio measurement.
  bit meas = 1'b0;
  int rises = 0;
  bit last_s = 1'b0;

  task automatic check_out(input bit e, input string phase);
    n_checks++;
    if (clk_out !== e) begin
      n_fail++;
      $display("FAIL %s (%s phase): clk_out=%b expected=%b at %0t",
               cur_req, phase, clk_out, e, $time);
    end
    n_checks++;
    if (clk_out_n !== ~e) begin
      n_fail++;
      $display("FAIL R7 (%s phase): clk_out_n=%b expected=%b at %0t",
               phase, clk_out_n, ~e, $time);
    end
    if (meas && clk_out && !last_s) rises++;
    last_s = clk_out;
  endtask

  always @(posedge clk) begin
    #1 check_out(exp_hi, "high");
  end
  always @(negedge clk) begin
    #1 check_out(exp_lo, "low");
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic measure(input int c);
    int want;
    code = c[1:0];
    oe   = 1'b1;
    cyc(24);
    rises = 0;
    meas  = 1'b1;
    cyc(32);
    meas  = 1'b0;
    want  = 32 / (1 << c);
    n_checks++;
    if (rises != want) begin
      n_fail++;
      $display("FAIL R1: code %0d rises=%0d expected=%0d", c, rises, want);
    end
  endtask

  initial begin
    rst  = 1'b1;
    code = 2'd0;
    oe   = 1'b0;
    cur_req = "R8";
    cyc(4);
    rst = 1'b0;
    cyc(6);

    // R1 R2: each ratio, steady state
    cur_req = "R1 R2";
    for (int c = 0; c < 4; c++) measure(c);
    for (int c = 3; c >= 0; c--) measure(c);

    // R3 R4: enable toggled at odd offsets inside long and short periods
    cur_req = "R3 R4";
    code = 2'd3;
    for (int k = 1; k < 12; k++) begin
      oe = ~oe;
      cyc(k);
    end
    code = 2'd0;
    for (int k = 1; k < 8; k++) begin
      oe = ~oe;
      cyc(k);
    end
    oe = 1'b0;
    cyc(20);

    // R5 R9: code changed mid-period, sometimes reverted before the wrap
    cur_req = "R5 R9";
    oe = 1'b1;
    code = 2'd3;
    cyc(16);
    for (int k = 0; k < 10; k++) begin
      code = 2'(k);
      cyc(3);
      code = 2'(k + 1);
      cyc(k % 5 + 1);
    end
    cyc(16);

    // R6: rapid swaps between the bypass and the counter path
    cur_req = "R6";
    for (int k = 0; k < 24; k++) begin
      code = (k % 2 == 0) ? 2'd0 : 2'(1 + (k % 3));
      cyc(1 + (k % 4));
    end
    cyc(16);

    // R8: reset while running, settings waiting at release
    cur_req = "R8";
    code = 2'd2;
    oe   = 1'b1;
    cyc(3);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cur_req = "R9";
    cyc(16);

    // R4 R5 R6: unconstrained mix
    cur_req = "R4 R5 R6";
    for (int k = 0; k < 600; k++) begin
      code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) oe = ~oe;
      cyc($urandom_range(1, 6));
    end
    oe = 1'b1;
    cyc(20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule